// File: doc/BRIEF.md
# Programmable Two-Digit Divide-by-N Counter

This block divides its clock by a programmable ratio N and marks each division period with a one-cycle zero-detect pulse. The count is held in two cascaded 4-bit down-counting digits. Each digit counts either in binary (modulo 16) or in decimal (modulo 10), and its mode input selects which. The upper digit steps only when the lower digit borrows. The count therefore walks down through a mixed-radix range. When it reaches 1, the next clock edge reloads the reload value, so no ratio of 1 can be produced. The reload value comes from the 8-bit preset, or from zero when preset use is turned off.

A reload value of zero gives the full modulus of the chosen radices: 256, 160 or 100. Driving `use_preset` low forces that full modulus whatever the preset holds. Output `q` is the top bit of the upper digit, so it toggles only when that digit reaches 8 or more. That happens when the preset's upper digit is 8 or above, or when the full modulus is in use.

The count runs through two named states. In COUNT, the count steps down by one each edge. When the count equals 1 it is in the RELOAD state, and the next edge performs the transition back to COUNT by loading the reload value. Reset forces a load and clears the pulse.

Top module: `divn_counter`

## Requirements
- R1: `digit_mode[0]` sets the radix of the lower digit (preset bits [3:0]) and `digit_mode[1]` sets the radix of the upper digit (preset bits [7:4]). A 1 selects decimal (the digit wraps from 0 to 9) and a 0 selects binary (the digit wraps from 0 to 15). The two selections are independent.
- R2: Every rising clock edge that is not a reload decrements the count by one. The upper digit steps only on the edge where the lower digit steps down from 0.
- R3: The edge after the count equals 1 loads the reload value that is present on the inputs at that edge, giving a divide ratio N for any valid preset with 2 <= N <= full modulus.
- R4: `zero_det` is high for exactly one clock cycle per period. That cycle is the one in which the freshly reloaded value is held, so consecutive pulses are N cycles apart.
- R5: A preset of zero divides by the full modulus: 256 with both digits binary, 160 with one digit decimal, and 100 with both digits decimal.
- R6: While `use_preset` is low, the preset is ignored and the block divides by the full modulus for the selected radices.
- R7: `q` equals bit 3 of the upper digit. It stays low through a whole period when the effective upper preset digit is below 8 and the effective preset is nonzero.
- R8: In decimal mode, a preset digit above 9 is loaded as 9.
- R9: A synchronous reset loads the reload value and holds `zero_det` low. After reset is released, the first pulse appears after exactly N clock edges.
- R10: A preset of 1 is illegal. It holds the count at 1, so `zero_det` stays high on every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the count steps on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| digit_mode | input | 2 | Radix per digit, bit 0 lower: 1 decimal, 0 binary |
| preset | input | 8 | Divide ratio N, lower digit in bits [3:0] |
| use_preset | input | 1 | High: load preset; low: force full modulus |
| zero_det | output | 1 | One-cycle pulse once per period |
| q | output | 1 | Top bit of the upper digit |

## Verification
The pulse of `zero_det` is registered. It appears in the sample taken after the edge that follows the count of 1, so after a reset release the first pulse is due N falling-edge samples later. From then on, each further pulse is due exactly N samples after the one before. Inputs change on falling edges and outputs are read on falling edges, so every result is counted in whole cycles from the stimulus edge. `q` is read directly from the upper digit's register and is checked over a full period. A preset change made during a pulse cycle is expected to show only in the gap to the second following pulse.

// File: rtl/divn_pkg.sv
`timescale 1ns/1ps
package divn_pkg;
    localparam int DIGIT_W = 4;

    typedef enum logic {
        RADIX_BIN = 1'b0,
        RADIX_BCD = 1'b1
    } radix_e;

    function automatic logic [DIGIT_W-1:0] digit_top(radix_e r);
        return (r == RADIX_BCD) ? DIGIT_W'(9) : DIGIT_W'(15);
    endfunction
endpackage

// File: rtl/divn_digit.sv
`timescale 1ns/1ps
module divn_digit
    import divn_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  radix_e             radix,
    input  logic               load,
    input  logic [DIGIT_W-1:0] load_val,
    input  logic               step,
    output logic [DIGIT_W-1:0] val,
    output logic               borrow
);
    assign borrow = step && (val == '0);

    always_ff @(posedge clk) begin
        if (rst || load) begin
            val <= load_val;
        end else if (step) begin
            val <= (val == '0) ? digit_top(radix) : val - 1'b1;
        end
    end

    // R2: a step that is not a load lowers the digit by one
    a_r2_step_down: assert property (@(posedge clk) disable iff (rst)
        (step && !load && val != '0) |=> (val == $past(val) - 1'b1));

    // R1: stepping from zero wraps to the radix top
    a_r1_wrap_radix: assert property (@(posedge clk) disable iff (rst)
        (step && !load && val == '0) |=>
            (val == (($past(radix) == RADIX_BCD) ? DIGIT_W'(9) : DIGIT_W'(15))));
endmodule

// File: rtl/divn_reload.sv
`timescale 1ns/1ps
module divn_reload
    import divn_pkg::*;
#(
    parameter int NUM_DIGITS = 2
) (
    input  logic [NUM_DIGITS*DIGIT_W-1:0] preset,
    input  logic [NUM_DIGITS-1:0]         digit_mode,
    input  logic                          use_preset,
    output logic [NUM_DIGITS*DIGIT_W-1:0] reload
);
    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_dig
        logic [DIGIT_W-1:0] raw;
        assign raw = use_preset ? preset[i*DIGIT_W +: DIGIT_W] : '0;
        assign reload[i*DIGIT_W +: DIGIT_W] =
            (digit_mode[i] && raw > DIGIT_W'(9)) ? DIGIT_W'(9) : raw;
    end
endmodule

// File: rtl/divn_counter.sv
`timescale 1ns/1ps
module divn_counter
    import divn_pkg::*;
#(
    parameter int NUM_DIGITS = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_DIGITS-1:0]         digit_mode,
    input  logic [NUM_DIGITS*DIGIT_W-1:0] preset,
    input  logic                          use_preset,
    output logic                          zero_det,
    output logic                          q
);
    localparam int CNT_W = NUM_DIGITS * DIGIT_W;

    logic [CNT_W-1:0]      reload;
    logic [CNT_W-1:0]      count;
    logic [NUM_DIGITS:0]   carry;
    logic                  at_one;

    divn_reload #(.NUM_DIGITS(NUM_DIGITS)) u_reload (
        .preset     (preset),
        .digit_mode (digit_mode),
        .use_preset (use_preset),
        .reload     (reload)
    );

    assign carry[0] = 1'b1;
    assign at_one   = (count == CNT_W'(1));

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
        divn_digit u_digit (
            .clk      (clk),
            .rst      (rst),
            .radix    (radix_e'(digit_mode[i])),
            .load     (at_one),
            .load_val (reload[i*DIGIT_W +: DIGIT_W]),
            .step     (carry[i]),
            .val      (count[i*DIGIT_W +: DIGIT_W]),
            .borrow   (carry[i+1])
        );

        // R8: a decimal digit never reloads above nine
        a_r8_bcd_limit: assert property (@(posedge clk) disable iff (rst)
            digit_mode[i] |-> (reload[i*DIGIT_W +: DIGIT_W] <= DIGIT_W'(9)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            zero_det <= 1'b0;
        end else begin
            zero_det <= at_one;
        end
    end

    assign q = count[CNT_W-1];

    // R3: count of one is followed by the reload value
    a_r3_reload: assert property (@(posedge clk) disable iff (rst)
        at_one |=> (count == $past(reload)));

    // R4: a pulse not followed by another reload lasts one cycle
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (zero_det && !at_one) |=> !zero_det);

    // R4: a pulse only starts after the count sat at one
    a_r4_pulse_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(zero_det) |-> $past(at_one));

    // R6: preset disabled forces the zero reload
    a_r6_forced_max: assert property (@(posedge clk) disable iff (rst)
        !use_preset |-> (reload == '0));

    // R5: a borrow out of the top digit wraps to a nonzero count
    a_r5_full_wrap: assert property (@(posedge clk) disable iff (rst)
        carry[NUM_DIGITS] |=> (count != '0));
endmodule

// File: tb/divn_counter_bench.sv
`timescale 1ns/1ps
module divn_counter_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] digit_mode = 2'b00;
    logic [7:0] preset = 8'h00;
    logic       use_preset = 1'b1;
    logic       zero_det;
    logic       q;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    divn_counter u_divn_counter (
        .clk        (clk),
        .rst        (rst),
        .digit_mode (digit_mode),
        .preset     (preset),
        .use_preset (use_preset),
        .zero_det   (zero_det),
        .q          (q)
    );

    // fields: [20:19] mode, [18] use_preset, [17:10] preset, [9:1] period, [0] q seen
    localparam int NV = 20;
    localparam logic [20:0] VECS [0:NV-1] = '{
        {2'b00, 1'b1, 8'h00, 9'd256, 1'b1},
        {2'b01, 1'b1, 8'h00, 9'd160, 1'b1},
        {2'b10, 1'b1, 8'h00, 9'd160, 1'b1},
        {2'b11, 1'b1, 8'h00, 9'd100, 1'b1},
        {2'b00, 1'b0, 8'h37, 9'd256, 1'b1},
        {2'b01, 1'b0, 8'h37, 9'd160, 1'b1},
        {2'b10, 1'b0, 8'h55, 9'd160, 1'b1},
        {2'b11, 1'b0, 8'h99, 9'd100, 1'b1},
        {2'b00, 1'b1, 8'h02, 9'd2,   1'b0},
        {2'b00, 1'b1, 8'h03, 9'd3,   1'b0},
        {2'b00, 1'b1, 8'h88, 9'd136, 1'b1},
        {2'b01, 1'b1, 8'h19, 9'd19,  1'b0},
        {2'b01, 1'b1, 8'h1F, 9'd19,  1'b0},
        {2'b00, 1'b1, 8'h1F, 9'd31,  1'b0},
        {2'b10, 1'b1, 8'h9F, 9'd159, 1'b1},
        {2'b11, 1'b1, 8'h99, 9'd99,  1'b1},
        {2'b11, 1'b1, 8'hFF, 9'd99,  1'b1},
        {2'b01, 1'b1, 8'hF9, 9'd159, 1'b1},
        {2'b11, 1'b1, 8'h42, 9'd42,  1'b0},
        {2'b00, 1'b1, 8'h7F, 9'd127, 1'b0}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] m, input logic up, input logic [7:0] p);
        @(negedge clk);
        digit_mode = m;
        use_preset = up;
        preset     = p;
        rst        = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // counts falling-edge samples until zero_det is seen high
    task automatic wait_pulse(output int n, output bit q_hi);
        n = 0;
        q_hi = 1'b0;
        for (int k = 0; k < 1000; k++) begin
            @(negedge clk);
            n++;
            if (q) q_hi = 1'b1;
            if (zero_det) break;
        end
    endtask

    initial begin
        #750000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int first, gap, gap2;
        bit qh;

        // R9 reset state: pulse held low, q reflects loaded upper digit
        do_reset(2'b00, 1'b1, 8'h88);
        rst = 1'b1;
        @(negedge clk);
        check(zero_det == 1'b0, "R9", "zero_det in reset", int'(zero_det), 0);
        check(q == 1'b1, "R7", "q in reset preset 0x88", int'(q), 1);
        preset = 8'h37;
        @(negedge clk);
        check(q == 1'b0, "R7", "q in reset preset 0x37", int'(q), 0);
        rst = 1'b0;

        // table walk: first-pulse delay, period and q activity (R1 R3 R4 R5 R6 R7 R8 R9)
        for (int v = 0; v < NV; v++) begin
            do_reset(VECS[v][20:19], VECS[v][18], VECS[v][17:10]);
            wait_pulse(first, qh);
            check(first == int'(VECS[v][9:1]), "R9", $sformatf("first pulse vec %0d", v),
                  first, int'(VECS[v][9:1]));
            wait_pulse(gap, qh);
            check(gap == int'(VECS[v][9:1]), "R3/R4/R5", $sformatf("period vec %0d", v),
                  gap, int'(VECS[v][9:1]));
            check(qh == VECS[v][0], "R7", $sformatf("q seen vec %0d", v),
                  int'(qh), int'(VECS[v][0]));
        end

        // R10: preset of one keeps zero_det high every cycle
        do_reset(2'b00, 1'b1, 8'h01);
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            check(zero_det == 1'b1, "R10", $sformatf("held pulse cycle %0d", k),
                  int'(zero_det), 1);
        end

        // R9: reset during a pulse clears it on the next edge
        do_reset(2'b00, 1'b1, 8'h02);
        repeat (2) @(negedge clk);
        check(zero_det == 1'b1, "R4", "pulse before mid reset", int'(zero_det), 1);
        rst = 1'b1;
        @(negedge clk);
        check(zero_det == 1'b0, "R9", "pulse cleared by reset", int'(zero_det), 0);
        rst = 1'b0;

        // R3: a preset change in a pulse cycle acts at the following reload
        do_reset(2'b00, 1'b1, 8'h05);
        wait_pulse(first, qh);
        preset = 8'h03;
        wait_pulse(gap, qh);
        wait_pulse(gap2, qh);
        check(gap == 5, "R3", "gap using old preset", gap, 5);
        check(gap2 == 3, "R3", "gap using new preset", gap2, 3);

        // R2/R1: mixed radix 0x20 with lower decimal gives 2*10 cycles
        do_reset(2'b01, 1'b1, 8'h20);
        wait_pulse(first, qh);
        wait_pulse(gap, qh);
        check(gap == 20, "R2", "borrow into upper digit lower decimal", gap, 20);
        do_reset(2'b00, 1'b1, 8'h20);
        wait_pulse(first, qh);
        wait_pulse(gap, qh);
        check(gap == 32, "R1", "borrow into upper digit lower binary", gap, 32);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule